// File: doc/BRIEF.md
# Interrupt Acceptance Controller

This block sits beside an 8-bit processor's sequencer and decides, each time the sequencer signals an instruction boundary, whether to start a reset, a non-maskable interrupt or a maskable interrupt. It holds the two interrupt enable flip-flops (the live enable and its saved copy) and the 2-bit interrupt mode. It updates them from the enable, disable, return-from-NMI and mode-select commands that the instruction decoder issues.

Reset and non-maskable requests produce an action pulse and a fixed target address in the cycle after the boundary. A maskable interrupt first waits a configurable number of bus-settle cycles. It then raises an acknowledge request for one cycle, during which the device places a byte on the data input. From that byte the block forms the target: a fixed restart address, a 16-bit vector made of the page register and the byte, or the byte itself, which the sequencer executes as an instruction. The saved enable is exported so that the flag logic can copy it into the parity/overflow flag when the page or refresh register is read.

Top module: `irq_accept`

## Requirements
- R1: A boundary with `rst_line` high takes priority over every other request. It produces action code 1 with vector 0x0000, and it clears both enables, the mode and any latched non-maskable request.
- R2: A rising edge on `nmi_line` is latched until it is serviced. Servicing produces action code 2 with vector 0x0066, copies the live enable into the saved enable, clears the live enable, and clears the latch.
- R3: A high level on `int_line` is taken at a boundary only when the live enable is set and neither a reset nor a latched non-maskable request is present. Otherwise the boundary produces no action.
- R4: Accepting a maskable interrupt clears both enables at the boundary edge. With the boundary sampled at edge k, `ack_req` is high only in the cycle after edge k+2, and `ack_data` is sampled at edge k+3.
- R5: The action after edge k+3 follows the mode captured at acceptance. Mode 0 gives code 3 with vector {0x00, data}. Mode 1 gives code 4 with vector 0x0038. Mode 2 gives code 5 with vector {`page_reg`, data}.
- R6: A mode-select command decodes `im_field` as follows: values 0, 1, 4 and 5 give mode 0; values 2 and 6 give mode 1; values 3 and 7 give mode 2.
- R7: The disable command clears both enables. The enable command sets both. Disable wins over enable when both are given.
- R8: The return command copies the saved enable into the live enable.
- R9: `halt_release` is high while `rst_line` is high, while a non-maskable request is latched, or while `int_line` is high with the live enable set.
- R10: `act` is 0 and `vec` is 0x0000 in every cycle that carries no action. Boundaries that arrive during a maskable-interrupt sequence are ignored, and a non-maskable edge seen then stays latched.
- R11: The action for a reset or a non-maskable request appears in the cycle after the boundary edge and lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low clear |
| rst_line | input | 1 | Reset request, acted on at a boundary |
| nmi_line | input | 1 | Non-maskable request, rising-edge latched |
| int_line | input | 1 | Maskable request, level sampled at a boundary |
| boundary | input | 1 | Instruction-boundary strobe |
| cmd_di | input | 1 | Disable-interrupts command |
| cmd_ei | input | 1 | Enable-interrupts command |
| cmd_retn | input | 1 | Return-from-interrupt command (restore enable) |
| cmd_im | input | 1 | Mode-select command |
| im_field | input | 3 | Opcode field of the mode-select command |
| page_reg | input | 8 | Interrupt page register value |
| ack_data | input | 8 | Data byte from the acknowledge cycle |
| iff1 | output | 1 | Live interrupt enable |
| iff2 | output | 1 | Saved interrupt enable |
| im_mode | output | 2 | Current interrupt mode |
| act | output | 3 | Action: 0 none, 1 reset, 2 NMI, 3/4/5 INT mode 0/1/2 |
| vec | output | 16 | Target address (mode 0: acknowledge byte) |
| halt_release | output | 1 | Leave the halt state |
| ack_req | output | 1 | Request for the interrupt acknowledge cycle |

## Verification
The bench sweeps all sixteen combinations of reset, latched non-maskable, maskable level and enable state. A wrong priority order, or a maskable interrupt taken while disabled, shows up there as the wrong action code. It sweeps all eight mode fields against three data bytes, which exposes a mode-alias decode that collapses values 4 to 7 or swaps modes 1 and 2, and a mode-2 vector whose bytes are reversed. It also covers the save and restore of the enable across a non-maskable entry and a return, which a design that cleared the saved copy would fail. Finally it sends a non-maskable edge while a maskable sequence is still settling; a design that served or lost that edge would give the wrong action.

// File: rtl/irq_accept.sv
module irq_accept #(
  parameter int          SETTLE_CYC = 2,
  parameter logic [15:0] RST_VEC    = 16'h0000,
  parameter logic [15:0] NMI_VEC    = 16'h0066,
  parameter logic [15:0] IM1_VEC    = 16'h0038
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rst_line,
  input  logic        nmi_line,
  input  logic        int_line,
  input  logic        boundary,
  input  logic        cmd_di,
  input  logic        cmd_ei,
  input  logic        cmd_retn,
  input  logic        cmd_im,
  input  logic [2:0]  im_field,
  input  logic [7:0]  page_reg,
  input  logic [7:0]  ack_data,
  output logic        iff1,
  output logic        iff2,
  output logic [1:0]  im_mode,
  output logic [2:0]  act,
  output logic [15:0] vec,
  output logic        halt_release,
  output logic        ack_req
);
  localparam int CW = $clog2(SETTLE_CYC + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(SETTLE_CYC - 1);
  localparam logic [2:0] A_NONE = 3'd0, A_RST = 3'd1, A_NMI = 3'd2,
                         A_INT0 = 3'd3, A_INT1 = 3'd4, A_INT2 = 3'd5;
  localparam logic [1:0] S_IDLE = 2'd0, S_SETTLE = 2'd1, S_ACK = 2'd2;

  logic [1:0]    st;
  logic [CW-1:0] cnt;
  logic [1:0]    imode_q;
  logic          nmi_d, nmi_pend;
  logic          busy;
  logic          take_rst, take_nmi, take_int;
  logic [1:0]    im_dec;

  assign busy     = (st != S_IDLE);
  assign take_rst = boundary & ~busy & rst_line;
  assign take_nmi = boundary & ~busy & ~rst_line & nmi_pend;
  assign take_int = boundary & ~busy & ~rst_line & ~nmi_pend & int_line & iff1;
  assign im_dec   = im_field[1] ? (im_field[0] ? 2'd2 : 2'd1) : 2'd0;

  assign ack_req      = (st == S_ACK);
  assign halt_release = rst_line | nmi_pend | (int_line & iff1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_d    <= 1'b0;
      nmi_pend <= 1'b0;
    end else begin
      nmi_d    <= nmi_line;
      nmi_pend <= (nmi_line & ~nmi_d) | (nmi_pend & ~(take_nmi | take_rst));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iff1    <= 1'b0;
      iff2    <= 1'b0;
      im_mode <= 2'd0;
    end else if (take_rst) begin
      iff1    <= 1'b0;
      iff2    <= 1'b0;
      im_mode <= 2'd0;
    end else if (take_nmi) begin
      iff2 <= iff1;
      iff1 <= 1'b0;
    end else if (take_int) begin
      iff1 <= 1'b0;
      iff2 <= 1'b0;
    end else begin
      if (cmd_di) begin
        iff1 <= 1'b0;
        iff2 <= 1'b0;
      end else if (cmd_ei) begin
        iff1 <= 1'b1;
        iff2 <= 1'b1;
      end else if (cmd_retn) begin
        iff1 <= iff2;
      end
      if (cmd_im) im_mode <= im_dec;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      imode_q <= 2'd0;
    end else begin
      case (st)
        S_IDLE: if (take_int) begin
          st      <= S_SETTLE;
          cnt     <= '0;
          imode_q <= im_mode;
        end
        S_SETTLE: if (cnt == CNT_LAST) st <= S_ACK;
                  else cnt <= cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act <= A_NONE;
      vec <= '0;
    end else begin
      act <= A_NONE;
      vec <= '0;
      if (take_rst) begin
        act <= A_RST;
        vec <= RST_VEC;
      end else if (take_nmi) begin
        act <= A_NMI;
        vec <= NMI_VEC;
      end else if (st == S_ACK) begin
        case (imode_q)
          2'd0:    begin act <= A_INT0; vec <= {8'h00, ack_data};  end
          2'd1:    begin act <= A_INT1; vec <= IM1_VEC;            end
          default: begin act <= A_INT2; vec <= {page_reg, ack_data}; end
        endcase
      end
    end
  end
endmodule

module irq_accept_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        boundary,
  input logic        rst_line,
  input logic        int_line,
  input logic        cmd_di,
  input logic        cmd_ei,
  input logic        cmd_retn,
  input logic        iff1,
  input logic        iff2,
  input logic [1:0]  im_mode,
  input logic [2:0]  act,
  input logic [15:0] vec,
  input logic        ack_req,
  input logic        nmi_pend,
  input logic        busy
);
  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    act == 3'd1 |-> !iff1 && !iff2 && im_mode == 2'd0); // R1
  AST_NMI_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
    act == 3'd2 |-> !iff1 && iff2 == $past(iff1)); // R2
  AST_INT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    boundary && !busy && !rst_line && !nmi_pend && !iff1 |=> act == 3'd0 && !busy); // R3
  AST_INT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    boundary && !busy && !rst_line && !nmi_pend && int_line && iff1 |=> !iff1 && !iff2 && busy); // R4
  AST_ACK_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |=> act == 3'd3 || act == 3'd4 || act == 3'd5); // R5
  AST_DI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_di && !boundary |=> !iff1 && !iff2); // R7
  AST_EI_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ei && !cmd_di && !boundary |=> iff1 && iff2); // R7
  AST_RETN_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_retn && !cmd_di && !cmd_ei && !boundary |=> iff1 == $past(iff2)); // R8
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    act == 3'd0 |-> vec == 16'h0000); // R10
endmodule

bind irq_accept irq_accept_chk u_chk (
  .clk(clk), .rst_n(rst_n), .boundary(boundary), .rst_line(rst_line),
  .int_line(int_line), .cmd_di(cmd_di), .cmd_ei(cmd_ei), .cmd_retn(cmd_retn),
  .iff1(iff1), .iff2(iff2), .im_mode(im_mode), .act(act), .vec(vec),
  .ack_req(ack_req), .nmi_pend(nmi_pend), .busy(busy)
);

// File: tb/irq_accept_bench.sv
module irq_accept_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rst_line = 0, nmi_line = 0, int_line = 0, boundary = 0;
  logic cmd_di = 0, cmd_ei = 0, cmd_retn = 0, cmd_im = 0;
  logic [2:0] im_field = 0;
  logic [7:0] page_reg = 0, ack_data = 0;
  logic iff1, iff2, halt_release, ack_req;
  logic [1:0] im_mode;
  logic [2:0] act;
  logic [15:0] vec;
  int nvec = 0, nbad = 0;
  bit done = 0;

  irq_accept u_irq_accept (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    nvec++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  endtask

  task automatic clean();
    rst_line = 1; boundary = 1; step();
    rst_line = 0; boundary = 0; step();
  endtask

  task automatic pulse_nmi();
    nmi_line = 1; step(); nmi_line = 0; step();
  endtask

  task automatic enable();
    cmd_ei = 1; step(); cmd_ei = 0;
  endtask

  function automatic logic [15:0] exp_vec(int m, logic [7:0] d, logic [7:0] pg);
    if (m == 0) return {8'h00, d};
    if (m == 1) return 16'h0038;
    return {pg, d};
  endfunction

  // accept a maskable interrupt now, run the sequence and check the outcome
  task automatic run_int(int m, logic [7:0] d, logic [7:0] pg);
    int_line = 1; boundary = 1; step();
    int_line = 0; boundary = 0;
    chk("R4 enables cleared on accept", {iff1, iff2}, 2'b00);
    chk("R4 no action at accept", act, 0);
    step();
    chk("R4 ack_req low while settling", ack_req, 0);
    step();
    chk("R4 ack_req high", ack_req, 1);
    ack_data = d; page_reg = pg;
    step();
    chk("R5 action code", act, 3 + m);
    chk("R5 vector", vec, exp_vec(m, d, pg));
    chk("R4 ack_req drops", ack_req, 0);
    step();
    chk("R10 action is a pulse", {act, vec}, 19'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    step(); rst_n = 1; step();
    chk("R1 reset state enables", {iff1, iff2}, 2'b00);
    chk("R1 reset state mode", im_mode, 0);
    chk("R10 reset state action", {act, vec}, 19'd0);
    chk("R9 reset state halt_release", halt_release, 0);
    chk("R4 reset state ack_req", ack_req, 0);

    // priority sweep over reset, latched NMI, INT level and enable
    for (int c = 0; c < 16; c++) begin
      bit rr, nn, ii, ee;
      int e;
      {rr, nn, ii, ee} = 4'(c);
      clean();
      if (ee) enable();
      if (nn) pulse_nmi();
      rst_line = rr; int_line = ii;
      #1;
      chk("R9 halt_release", halt_release, rr | nn | (ii & ee));
      e = rr ? 1 : nn ? 2 : (ii & ee) ? 3 : 0;
      if (e == 3) begin
        rst_line = 0;
        run_int(0, 8'hC7, 8'h12);
      end else begin
        boundary = 1; step();
        boundary = 0; rst_line = 0; int_line = 0;
        chk("R3 R11 priority action", act, e);
        if (e == 1) begin
          chk("R1 vector", vec, 16'h0000);
          chk("R1 enables cleared", {iff1, iff2}, 2'b00);
        end else if (e == 2) begin
          chk("R2 vector", vec, 16'h0066);
          chk("R2 enable saved", {iff1, iff2}, {1'b0, ee});
        end else begin
          chk("R3 no action keeps enable", iff1, ee);
        end
        step();
        chk("R11 action lasts one cycle", act, 0);
        boundary = 1; step(); boundary = 0;
        chk("R1 R2 latch cleared after service", act, 0);
      end
    end

    // mode field sweep against several acknowledge bytes
    for (int y = 0; y < 8; y++) begin
      for (int k = 0; k < 3; k++) begin
        logic [7:0] d;
        int m;
        d = (k == 0) ? 8'h00 : (k == 1) ? 8'h5A : 8'hFF;
        m = ((y & 3) < 2) ? 0 : (y & 3) - 1;
        clean();
        cmd_im = 1; im_field = 3'(y); step(); cmd_im = 0;
        chk("R6 mode decode", im_mode, m);
        enable();
        run_int(m, d, 8'(y * 16 + 1));
      end
    end

    // enable save and restore across NMI entry and return
    clean(); enable(); pulse_nmi();
    boundary = 1; step(); boundary = 0;
    chk("R2 NMI taken", act, 2);
    chk("R2 saved enable", {iff1, iff2}, 2'b01);
    cmd_retn = 1; step(); cmd_retn = 0;
    chk("R8 return restores enable", {iff1, iff2}, 2'b11);
    cmd_di = 1; step(); cmd_di = 0;
    chk("R7 disable clears both", {iff1, iff2}, 2'b00);
    cmd_retn = 1; step(); cmd_retn = 0;
    chk("R8 return with saved clear", iff1, 0);
    cmd_di = 1; cmd_ei = 1; step(); cmd_di = 0; cmd_ei = 0;
    chk("R7 disable wins over enable", {iff1, iff2}, 2'b00);
    enable();
    chk("R7 enable sets both", {iff1, iff2}, 2'b11);

    // boundaries ignored while a maskable sequence runs; NMI stays latched
    clean(); enable();
    int_line = 1; boundary = 1; step(); int_line = 0; boundary = 0;
    nmi_line = 1; boundary = 1; step(); nmi_line = 0; boundary = 0;
    chk("R10 boundary ignored while busy", act, 0);
    step();
    chk("R10 ack_req on schedule while busy", ack_req, 1);
    ack_data = 8'h3C; step();
    chk("R10 maskable completes", act, 3);
    chk("R9 latched NMI releases halt", halt_release, 1);
    boundary = 1; step(); boundary = 0;
    chk("R10 NMI kept latched", act, 2);
    chk("R2 NMI vector after busy", vec, 16'h0066);

    finish_run();
  end
endmodule